// File: doc/BRIEF.md
# Cacheability-Aware Bus Access Sequencer

This block sits between a processor's first-level cache controller and a 128-bit pipelined system bus. Each request carries an operation (instruction fetch, load or store), an address, an access size, an address-space code, a cache-enable flag and a hit flag. The block works out whether the address lies in a cacheable region. From that it picks one of four actions: a line-fill burst of 128-bit beats, a four-word burst of 32-bit reads, a single beat of the request's own size, or no bus traffic at all. No bus traffic happens for a cache hit and for an illegal access.

A request is taken only while the block is idle. Once taken, the block runs the AHB-style address and data phases. It stretches every phase while the slave holds `hready` low. Each read beat is handed back on a registered data port. A completed request ends with a one-cycle `rsp_done` pulse. A rejected request ends with a one-cycle `rsp_err` pulse and has no bus transfer.

The controller has four named states:
- `ST_IDLE` accepts a request and goes to `ST_XFER` (bus action), `ST_DONE` (hit) or `ST_FAULT` (illegal).
- `ST_XFER` issues and completes the beats and goes to `ST_DONE` when the last data phase completes.
- `ST_DONE` and `ST_FAULT` each last one cycle and return to `ST_IDLE`.

Top module: `bus_access_seq`

## Requirements
- R1: An address is cacheable exactly when it lies in 0x00000000–0x7FFFFFFF or in 0xC0000000–0xCFFFFFFF. Every other address is uncacheable.
- R2: A fetch (`req_op`=0) or load (`req_op`=1) that is not a bypass, goes to a cacheable address with the cache enabled, and misses, issues a 2-beat incrementing burst (`hburst`=3'b001, `hsize`=3'd4 for 128 bits). The burst starts at the address rounded down to 32 bytes, and the second beat is 16 bytes higher. The first beat is NONSEQ (`htrans`=2'b10) and the second is SEQ (2'b11).
- R3: A load with `req_asi`=0x1C issues one single read (`hburst`=3'b000, `hsize`=`req_size`) at `req_addr`, whatever the region, cache enable or hit flag.
- R4: A 64-bit (`req_size`=3) load or store to an uncacheable address, or a request with the reserved `req_op`=3, pulses `rsp_err` in the cycle after acceptance and drives no address phase.
- R5: A 64-bit store to a cacheable address issues exactly one write with `hsize`=3. Its `hwdata` carries `req_wdata` in both 64-bit halves.
- R6: A store of 8, 16 or 32 bits (`req_size` 0, 1, 2) issues one single write with `hsize`=`req_size` in any region. The hit flag has no effect on stores.
- R7: A fetch that cannot use a line fill (uncacheable, or cache disabled) issues a 4-beat burst (`hburst`=3'b011) of 32-bit reads (`hsize`=2). It starts at the address rounded down to 16 bytes and steps by 4.
- R8: A non-bypass load that cannot use a line fill (uncacheable region, or cache disabled) issues one single read of its own size. This includes a 64-bit read from a cacheable region.
- R9: A fetch or non-bypass load that hits in a cacheable region with the cache enabled drives no address phase. It pulses `rsp_done` in the cycle after acceptance.
- R10: `req_ready` is high only while idle, including right after reset. `rsp_done` and `rsp_err` are single-cycle pulses.
- R11: While `hready` is low, the pending address phase and its controls stay unchanged. Each completed read beat appears on `rd_valid` one cycle later, with that beat's `hrdata` and index `rd_beat`. `rsp_done` follows the last data phase by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved |
| req_size | input | 2 | 0/1/2/3 = 8/16/32/64 bits |
| req_addr | input | 32 | Byte address |
| req_asi | input | 8 | Address-space code; 0x1C forces a cache bypass on loads |
| req_cache_en | input | 1 | First-level cache enabled |
| req_hit | input | 1 | Lookup hit |
| req_wdata | input | 64 | Store data |
| rsp_done | output | 1 | Request finished |
| rsp_err | output | 1 | Request rejected as illegal |
| rd_valid | output | 1 | Read beat returned |
| rd_beat | output | 3 | Index of returned beat |
| rd_data | output | 128 | Returned read data |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | 00 idle, 10 first beat, 11 following beat |
| hwrite | output | 1 | Write transfer |
| hsize | output | 3 | log2 of beat bytes |
| hburst | output | 3 | 000 single, 001 incrementing, 011 four-beat |
| hwdata | output | 128 | Write data |
| hrdata | input | 128 | Read data |
| hready | input | 1 | Slave ready, low stretches a phase |

## Verification
A hit or an illegal request must answer in the first falling-edge sample after the edge that accepted it. A bus request's `rsp_done` must appear exactly one cycle after the edge that completed its last data phase, and each read beat shows on `rd_valid` in the same sample window as the following cycle. The bench drives all inputs and samples all outputs at falling edges. It keeps its own slave model that logs every accepted address phase and the cycle of each completed data phase. It then compares the response's arrival cycle against that log, so random `hready` stalls move the expected cycle with the actual one.

// File: rtl/bas_pkg.sv
package bas_pkg;

    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 128;
    localparam int WDATA_W     = 64;
    localparam int ASI_W       = 8;
    localparam int LINE_BYTES  = 32;
    localparam int BEAT_BYTES  = DATA_W / 8;
    localparam int FILL_BEATS  = LINE_BYTES / BEAT_BYTES;
    localparam int WORD_BYTES  = 4;
    localparam int FETCH_BEATS = 4;
    localparam int BEAT_W      = $clog2(FETCH_BEATS + 1);
    localparam int STRIDE_W    = $clog2(BEAT_BYTES) + 1;
    localparam int N_CREG      = 2;

    localparam logic [ASI_W-1:0] BYPASS_ASI = 8'h1C;

    // region i is cacheable when (addr & mask_i) == match_i
    localparam logic [N_CREG*ADDR_W-1:0] CREG_MASK  = {32'hF000_0000, 32'h8000_0000};
    localparam logic [N_CREG*ADDR_W-1:0] CREG_MATCH = {32'hC000_0000, 32'h0000_0000};

    localparam logic [1:0] OP_FETCH = 2'd0;
    localparam logic [1:0] OP_LOAD  = 2'd1;
    localparam logic [1:0] OP_STORE = 2'd2;

    localparam logic [1:0] HT_IDLE   = 2'b00;
    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [1:0] HT_SEQ    = 2'b11;

    localparam logic [2:0] HB_SINGLE = 3'b000;
    localparam logic [2:0] HB_INCR   = 3'b001;
    localparam logic [2:0] HB_INCR4  = 3'b011;

    localparam logic [2:0] HS_WORD = 3'd2;
    localparam logic [2:0] HS_LINE = 3'($clog2(BEAT_BYTES));

    typedef enum logic [1:0] {ACT_BUS, ACT_HIT, ACT_ERR} act_e;

    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE, ST_FAULT} st_e;

    typedef struct packed {
        act_e                act;
        logic                write;
        logic [BEAT_W-1:0]   beats_m1;
        logic [ADDR_W-1:0]   base;
        logic [2:0]          hsize;
        logic [2:0]          hburst;
        logic [STRIDE_W-1:0] stride;
    } plan_t;

endpackage

// File: rtl/bas_region_dec.sv
module bas_region_dec #(
    parameter int ADDR_W = bas_pkg::ADDR_W,
    parameter int N_REG  = bas_pkg::N_CREG,
    parameter logic [N_REG*ADDR_W-1:0] REG_MASK  = bas_pkg::CREG_MASK,
    parameter logic [N_REG*ADDR_W-1:0] REG_MATCH = bas_pkg::CREG_MATCH
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              cacheable
);

    logic [N_REG-1:0] in_reg;

    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        assign in_reg[g] = (addr & REG_MASK[g*ADDR_W +: ADDR_W])
                           == REG_MATCH[g*ADDR_W +: ADDR_W];
    end

    assign cacheable = |in_reg;

endmodule

// File: rtl/bas_classify.sv
module bas_classify
    import bas_pkg::*;
(
    input  logic [1:0]        op,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ASI_W-1:0]  asi,
    input  logic              cache_en,
    input  logic              hit,
    input  logic              cacheable,
    output plan_t             plan
);

    localparam logic [ADDR_W-1:0] LINE_MASK  = ADDR_W'(LINE_BYTES - 1);
    localparam logic [ADDR_W-1:0] FETCH_MASK = ADDR_W'(FETCH_BEATS * WORD_BYTES - 1);

    logic bypass;
    logic wide;
    logic fill_ok;

    assign bypass  = (op == OP_LOAD) && (asi == BYPASS_ASI);
    assign wide    = (size == 2'd3);
    assign fill_ok = cacheable && cache_en && !bypass;

    always_comb begin
        plan.act      = ACT_BUS;
        plan.write    = 1'b0;
        plan.beats_m1 = '0;
        plan.base     = addr;
        plan.hsize    = {1'b0, size};
        plan.hburst   = HB_SINGLE;
        plan.stride   = '0;
        if (op == 2'd3) begin
            plan.act = ACT_ERR;
        end else if (op != OP_FETCH && wide && !cacheable) begin
            plan.act = ACT_ERR;
        end else if (op == OP_STORE) begin
            plan.write = 1'b1;
        end else if (fill_ok && hit) begin
            plan.act = ACT_HIT;
        end else if (fill_ok) begin
            plan.beats_m1 = BEAT_W'(FILL_BEATS - 1);
            plan.base     = addr & ~LINE_MASK;
            plan.hsize    = HS_LINE;
            plan.hburst   = HB_INCR;
            plan.stride   = STRIDE_W'(BEAT_BYTES);
        end else if (op == OP_FETCH) begin
            plan.beats_m1 = BEAT_W'(FETCH_BEATS - 1);
            plan.base     = addr & ~FETCH_MASK;
            plan.hsize    = HS_WORD;
            plan.hburst   = HB_INCR4;
            plan.stride   = STRIDE_W'(WORD_BYTES);
        end
    end

endmodule

// File: rtl/bas_bus_fsm.sv
module bas_bus_fsm
    import bas_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  plan_t              plan_in,
    input  logic [WDATA_W-1:0] req_wdata,
    output logic               req_ready,
    output logic               rsp_done,
    output logic               rsp_err,
    output logic               rd_valid,
    output logic [BEAT_W-1:0]  rd_beat,
    output logic [DATA_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]  haddr,
    output logic [1:0]         htrans,
    output logic               hwrite,
    output logic [2:0]         hsize,
    output logic [2:0]         hburst,
    output logic [DATA_W-1:0]  hwdata,
    input  logic [DATA_W-1:0]  hrdata,
    input  logic               hready
);

    localparam int COPIES = DATA_W / WDATA_W;

    st_e                state, state_nxt;
    plan_t              plan_q;
    logic [WDATA_W-1:0] wdata_q;
    logic [BEAT_W-1:0]  acnt;
    logic [BEAT_W-1:0]  dcnt;
    logic               dpend;
    logic               addr_active;
    logic               last_data;
    logic               accept;
    logic [ADDR_W-1:0]  offset;

    assign accept      = (state == ST_IDLE) && req_valid;
    assign addr_active = (state == ST_XFER) && (acnt <= plan_q.beats_m1);
    assign last_data   = dpend && hready && (dcnt == plan_q.beats_m1);
    assign offset      = ADDR_W'(acnt) * ADDR_W'(plan_q.stride);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (plan_in.act)
                        ACT_ERR: state_nxt = ST_FAULT;
                        ACT_HIT: state_nxt = ST_DONE;
                        default: state_nxt = ST_XFER;
                    endcase
                end
            end
            ST_XFER:  if (last_data) state_nxt = ST_DONE;
            ST_DONE:  state_nxt = ST_IDLE;
            ST_FAULT: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_done  = (state == ST_DONE);
        rsp_err   = (state == ST_FAULT);
        htrans    = HT_IDLE;
        haddr     = '0;
        hwrite    = 1'b0;
        hsize     = 3'd0;
        hburst    = HB_SINGLE;
        if (addr_active) begin
            htrans = (acnt == '0) ? HT_NONSEQ : HT_SEQ;
            haddr  = plan_q.base + offset;
            hwrite = plan_q.write;
            hsize  = plan_q.hsize;
            hburst = plan_q.hburst;
        end
        hwdata = {COPIES{wdata_q}};
    end

    // transfer bookkeeping and read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plan_q   <= '0;
            wdata_q  <= '0;
            acnt     <= '0;
            dcnt     <= '0;
            dpend    <= 1'b0;
            rd_valid <= 1'b0;
            rd_beat  <= '0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (accept) begin
                plan_q  <= plan_in;
                wdata_q <= req_wdata;
                acnt    <= '0;
                dcnt    <= '0;
                dpend   <= 1'b0;
            end else if (state == ST_XFER && hready) begin
                if (addr_active) acnt <= acnt + 1'b1;
                dpend <= addr_active;
                if (dpend) begin
                    dcnt     <= dcnt + 1'b1;
                    rd_valid <= !plan_q.write;
                    rd_beat  <= dcnt;
                    rd_data  <= hrdata;
                end
            end
        end
    end

    assert_hold_ctrl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != HT_IDLE && !hready) |=>
            ($stable(haddr) && $stable(htrans) && $stable(hsize) && $stable(hwrite)));

    assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done || rsp_err) |=> !(rsp_done || rsp_err));

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_single_nonseq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == HT_NONSEQ && hready) |=> (htrans != HT_NONSEQ));

endmodule

// File: rtl/bus_access_seq.sv
module bus_access_seq
    import bas_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [ASI_W-1:0]    req_asi,
    input  logic                req_cache_en,
    input  logic                req_hit,
    input  logic [WDATA_W-1:0]  req_wdata,
    output logic                rsp_done,
    output logic                rsp_err,
    output logic                rd_valid,
    output logic [BEAT_W-1:0]   rd_beat,
    output logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   haddr,
    output logic [1:0]          htrans,
    output logic                hwrite,
    output logic [2:0]          hsize,
    output logic [2:0]          hburst,
    output logic [DATA_W-1:0]   hwdata,
    input  logic [DATA_W-1:0]   hrdata,
    input  logic                hready
);

    logic  req_cacheable;
    logic  bus_cacheable;
    plan_t plan;

    bas_region_dec u_req_region (
        .addr      (req_addr),
        .cacheable (req_cacheable)
    );

    bas_region_dec u_bus_region (
        .addr      (haddr),
        .cacheable (bus_cacheable)
    );

    bas_classify u_cls (
        .op        (req_op),
        .size      (req_size),
        .addr      (req_addr),
        .asi       (req_asi),
        .cache_en  (req_cache_en),
        .hit       (req_hit),
        .cacheable (req_cacheable),
        .plan      (plan)
    );

    bas_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .plan_in   (plan),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_done  (rsp_done),
        .rsp_err   (rsp_err),
        .rd_valid  (rd_valid),
        .rd_beat   (rd_beat),
        .rd_data   (rd_data),
        .haddr     (haddr),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .hsize     (hsize),
        .hburst    (hburst),
        .hwdata    (hwdata),
        .hrdata    (hrdata),
        .hready    (hready)
    );

    assert_no_wide_uncached_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != HT_IDLE && hsize == 3'd3) |-> bus_cacheable);

    assert_err_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && plan.act == ACT_ERR) |=> (rsp_err && htrans == HT_IDLE));

    assert_hit_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && plan.act == ACT_HIT) |=> (rsp_done && htrans == HT_IDLE));

endmodule

// File: tb/sim_bus_access_seq.sv
module sim_bus_access_seq;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_op = '0;
    logic [1:0]   req_size = '0;
    logic [31:0]  req_addr = '0;
    logic [7:0]   req_asi = '0;
    logic         req_cache_en = 1'b0;
    logic         req_hit = 1'b0;
    logic [63:0]  req_wdata = '0;
    logic         rsp_done, rsp_err, rd_valid;
    logic [2:0]   rd_beat;
    logic [127:0] rd_data;
    logic [31:0]  haddr;
    logic [1:0]   htrans;
    logic         hwrite;
    logic [2:0]   hsize, hburst;
    logic [127:0] hwdata;
    logic [127:0] hrdata = '0;
    logic         hready = 1'b1;

    bus_access_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_size(req_size), .req_addr(req_addr), .req_asi(req_asi),
        .req_cache_en(req_cache_en), .req_hit(req_hit), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rd_valid(rd_valid), .rd_beat(rd_beat),
        .rd_data(rd_data), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
        .hsize(hsize), .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata), .hready(hready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit all_ready = 1'b1;

    // slave model logs
    logic [31:0]  a_addr [0:7];
    logic [2:0]   a_size [0:7];
    logic [2:0]   a_burst[0:7];
    logic         a_wr   [0:7];
    logic [1:0]   a_trans[0:7];
    int           n_addr = 0;
    logic [127:0] r_data [0:7];
    int           r_beat [0:7];
    int           n_rd = 0;
    logic [127:0] w_data [0:7];
    int           n_wr = 0;
    int           last_data_cyc = -100;
    bit           dp_act = 1'b0;
    bit           dp_wr = 1'b0;
    logic [31:0]  dp_addr = '0;

    function automatic logic [127:0] slave_word(input logic [31:0] a);
        return {a ^ 32'h5A5A_0F0F, ~a, a + 32'd7, a};
    endfunction

    always @(negedge clk) begin
        cyc++;
        hready = all_ready ? 1'b1 : ($urandom_range(0, 3) != 0);
        hrdata = slave_word(dp_addr);
        if (dp_act && hready) begin
            if (dp_wr && n_wr < 8) begin w_data[n_wr] = hwdata; n_wr++; end
            last_data_cyc = cyc;
            dp_act = 1'b0;
        end
        if (htrans != 2'b00 && hready) begin
            if (n_addr < 8) begin
                a_addr[n_addr] = haddr; a_size[n_addr] = hsize; a_burst[n_addr] = hburst;
                a_wr[n_addr] = hwrite; a_trans[n_addr] = htrans;
            end
            n_addr++;
            dp_act = 1'b1; dp_addr = haddr; dp_wr = hwrite;
        end
        if (rd_valid) begin
            if (n_rd < 8) begin r_data[n_rd] = rd_data; r_beat[n_rd] = int'(rd_beat); end
            n_rd++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected action from the requirements
    // kind: 0 error, 1 hit, 2 bus
    task automatic exp_plan(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] a,
                            input logic [7:0] asi, input bit cen, input bit hit,
                            output int kind, output int nb, output logic [31:0] base,
                            output int stride, output logic [2:0] hs, output logic [2:0] hb,
                            output bit wr, output string tg);
        bit cach, byp, fill;
        cach = (a < 32'h8000_0000) || (a >= 32'hC000_0000 && a <= 32'hCFFF_FFFF);
        byp  = (op == 2'd1) && (asi == 8'h1C);
        fill = cach && cen && !byp;
        kind = 2; nb = 1; base = a; stride = 0; hs = {1'b0, sz}; hb = 3'b000; wr = 1'b0;
        if (op == 2'd3 || (op != 2'd0 && sz == 2'd3 && !cach)) begin
            kind = 0; tg = "R4";
        end else if (op == 2'd2) begin
            wr = 1'b1; tg = (sz == 2'd3) ? "R5" : "R6";
        end else if (fill && hit) begin
            kind = 1; tg = "R9";
        end else if (fill) begin
            nb = 2; base = a & ~32'd31; stride = 16; hs = 3'd4; hb = 3'b001; tg = "R2";
        end else if (op == 2'd0) begin
            nb = 4; base = a & ~32'd15; stride = 4; hs = 3'd2; hb = 3'b011; tg = "R7";
        end else begin
            tg = byp ? "R3" : "R8";
        end
    endtask

    task automatic run_req(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] a,
                           input logic [7:0] asi, input bit cen, input bit hit,
                           input logic [63:0] wd, input string ctx);
        int kind, nb, stride, t0, waited;
        logic [31:0] base;
        logic [2:0] hs, hb;
        bit wr, busy_ready;
        string tg;
        exp_plan(op, sz, a, asi, cen, hit, kind, nb, base, stride, hs, hb, wr, tg);
        tg = {ctx, tg};
        @(negedge clk); #1;
        chk(req_ready === 1'b1, "R10", {tg, " ready when idle"}, 128'(req_ready), 128'd1);
        n_addr = 0; n_rd = 0; n_wr = 0; last_data_cyc = -100;
        req_op = op; req_size = sz; req_addr = a; req_asi = asi;
        req_cache_en = cen; req_hit = hit; req_wdata = wd; req_valid = 1'b1;
        t0 = cyc;
        @(negedge clk); #1;
        req_valid = 1'b0;
        waited = 0; busy_ready = 1'b0;
        while (!(rsp_done || rsp_err) && waited < 300) begin
            if (req_ready) busy_ready = 1'b1;
            @(negedge clk); #1;
            waited++;
        end
        if (waited >= 300) begin
            chk(1'b0, tg, "no response", 128'(waited), 128'd0);
            return;
        end
        chk(!busy_ready, "R10", {tg, " ready low while busy"}, 128'(busy_ready), 128'd0);
        if (kind == 0) begin
            chk(rsp_err && !rsp_done, tg, "error pulse", {rsp_err, rsp_done}, 128'b10);
            chk(cyc == t0 + 1, tg, "error latency", 128'(cyc - t0), 128'd1);
            chk(n_addr == 0, tg, "no address phase on error", 128'(n_addr), 128'd0);
        end else if (kind == 1) begin
            chk(rsp_done && !rsp_err, tg, "hit done", {rsp_done, rsp_err}, 128'b10);
            chk(cyc == t0 + 1, tg, "hit latency", 128'(cyc - t0), 128'd1);
            chk(n_addr == 0, tg, "no address phase on hit", 128'(n_addr), 128'd0);
        end else begin
            chk(rsp_done && !rsp_err, tg, "bus done", {rsp_done, rsp_err}, 128'b10);
            chk(cyc == last_data_cyc + 1, "R11", {tg, " done after last data"},
                128'(cyc - last_data_cyc), 128'd1);
            chk(n_addr == nb, tg, "beat count", 128'(n_addr), 128'(nb));
            for (int i = 0; i < nb && i < n_addr && i < 8; i++) begin
                chk(a_addr[i] == base + 32'(i * stride), tg, "beat address",
                    128'(a_addr[i]), 128'(base + 32'(i * stride)));
                chk({a_size[i], a_burst[i], a_wr[i]} == {hs, hb, wr}, tg, "size/burst/write",
                    128'({a_size[i], a_burst[i], a_wr[i]}), 128'({hs, hb, wr}));
                chk(a_trans[i] == ((i == 0) ? 2'b10 : 2'b11), tg, "transfer type",
                    128'(a_trans[i]), 128'((i == 0) ? 2'b10 : 2'b11));
            end
            if (wr) begin
                chk(n_wr == 1, tg, "one write", 128'(n_wr), 128'd1);
                chk(w_data[0] == {wd, wd}, tg, "write data", w_data[0], {wd, wd});
            end else begin
                chk(n_rd == nb, "R11", {tg, " read beats returned"}, 128'(n_rd), 128'(nb));
                for (int i = 0; i < nb && i < n_rd && i < 8; i++) begin
                    chk(r_data[i] == slave_word(base + 32'(i * stride)), "R11",
                        {tg, " read data"}, r_data[i], slave_word(base + 32'(i * stride)));
                    chk(r_beat[i] == i, "R11", {tg, " beat index"}, 128'(r_beat[i]), 128'(i));
                end
            end
        end
        @(negedge clk); #1;
        chk(!rsp_done && !rsp_err, "R10", {tg, " response lasts one cycle"},
            {rsp_done, rsp_err}, 128'd0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] bases[8];
        void'($urandom(32'd4242));
        bases = '{32'h0000_1000, 32'h7FFF_FF00, 32'h8000_0000, 32'hBFFF_FF00,
                  32'hC000_0000, 32'hCFFF_FF00, 32'hD000_0000, 32'hFFFF_FF00};
        repeat (3) @(negedge clk);
        #1;
        // reset state (R10)
        chk(req_ready === 1'b1, "R10", "reset ready", 128'(req_ready), 128'd1);
        chk(htrans == 2'b00 && !rsp_done && !rsp_err && !rd_valid, "R10", "reset outputs quiet",
            {htrans, rsp_done, rsp_err, rd_valid}, 128'd0);
        rst_n = 1'b1;

        // R1 region edges, judged by 64-bit loads with the cache disabled (single vs error)
        run_req(2'd1, 2'd3, 32'h7FFF_FFF8, 8'h00, 1'b0, 1'b0, 64'h0, "R1 ");
        run_req(2'd1, 2'd3, 32'h8000_0000, 8'h00, 1'b0, 1'b0, 64'h0, "R1 ");
        run_req(2'd1, 2'd3, 32'hBFFF_FFF8, 8'h00, 1'b0, 1'b0, 64'h0, "R1 ");
        run_req(2'd1, 2'd3, 32'hC000_0000, 8'h00, 1'b0, 1'b0, 64'h0, "R1 ");
        run_req(2'd1, 2'd3, 32'hCFFF_FFF8, 8'h00, 1'b0, 1'b0, 64'h0, "R1 ");
        run_req(2'd1, 2'd3, 32'hD000_0000, 8'h00, 1'b0, 1'b0, 64'h0, "R1 ");
        // fills, fetches, bypass, stores, hits
        run_req(2'd1, 2'd2, 32'h0000_203C, 8'h00, 1'b1, 1'b0, 64'h0, "dir ");
        run_req(2'd0, 2'd2, 32'hC000_0014, 8'h00, 1'b1, 1'b0, 64'h0, "dir ");
        run_req(2'd0, 2'd2, 32'hE000_001C, 8'h00, 1'b1, 1'b0, 64'h0, "dir ");
        run_req(2'd0, 2'd2, 32'h0000_0108, 8'h00, 1'b0, 1'b0, 64'h0, "dir ");
        run_req(2'd1, 2'd0, 32'h0000_0103, 8'h1C, 1'b1, 1'b1, 64'h0, "dir ");
        run_req(2'd1, 2'd3, 32'hC000_0040, 8'h1C, 1'b1, 1'b0, 64'h0, "dir ");
        run_req(2'd2, 2'd3, 32'h0000_0300, 8'h00, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, "dir ");
        run_req(2'd2, 2'd3, 32'hF000_0300, 8'h00, 1'b1, 1'b0, 64'h1, "dir ");
        run_req(2'd2, 2'd1, 32'h9000_0002, 8'h00, 1'b1, 1'b1, 64'h0000_0000_0000_BEEF, "dir ");
        run_req(2'd1, 2'd2, 32'h0000_0400, 8'h00, 1'b1, 1'b1, 64'h0, "dir ");
        run_req(2'd0, 2'd2, 32'hC800_0000, 8'h00, 1'b1, 1'b1, 64'h0, "dir ");
        run_req(2'd3, 2'd2, 32'h0000_0000, 8'h00, 1'b1, 1'b0, 64'h0, "dir ");

        // random stimulus with bus stalls
        all_ready = 1'b0;
        for (int n = 0; n < 300; n++) begin
            logic [1:0] op, sz;
            logic [31:0] a;
            logic [7:0] asi;
            op  = 2'($urandom_range(0, 2));
            sz  = 2'($urandom_range(0, 3));
            a   = bases[$urandom_range(0, 7)] + 32'($urandom_range(0, 255));
            a   = a & ~((32'd1 << sz) - 32'd1);
            asi = ($urandom_range(0, 2) == 0) ? 8'h1C : 8'($urandom_range(0, 27));
            run_req(op, sz, a, asi, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    {$urandom, $urandom}, "rnd ");
        end
        finish_run();
    end

endmodule